// File: doc/BRIEF.md
# Scaled-Index Effective Address Stage

This block is one pipeline stage of a 64-bit load path. It computes the effective address for loads that scale an index register. The stage takes an already-decoded operation and the operand values read from the register file. The index is shifted left by one more bit than the shift field says, and the result is added to a base operand. Register storage, decode and the memory access are not part of the block.

Each operation is one of two kinds:

- **Plain indexed form.** A base register number of 0 means the literal value zero. The base register is never written.
- **Write-back form.** The base operand is always the register contents, even for register 0. The computed address is returned as a request to write it back into the base register.

A write-back form is illegal when its base register is 0 or is the same as its target register. In that case the stage raises a flag and drops the write-back request. No status state of any kind is changed by the stage.

One register stage separates the inputs from the outputs. A valid operation presented on one clock edge appears at the outputs after that edge, together with its address, write-back enable and write-back register number.

Top module: `sia_agen`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero on the following cycle.
- R2: `out_valid` equals the value of `in_valid` at the previous clock edge, so the latency is exactly one cycle.
- R3: `out_ea` equals the base operand plus (`in_index_val` shifted left by `in_shamt`+1), taken modulo 2^64. The shift comes before the add, and bits shifted past bit 63 are lost.
- R4: For a plain indexed form (`in_update`=0) with `in_base_idx`=0, the base operand is zero and `in_base_val` is ignored.
- R5: For a write-back form (`in_update`=1), the base operand is `in_base_val` for every value of `in_base_idx`, including 0.
- R6: A legal write-back form gives `out_wb_en`=1 and `out_wb_idx`=`in_base_idx`, with the write-back value on `out_ea`.
- R7: A plain indexed form always gives `out_wb_en`=0 and `out_illegal`=0.
- R8: A write-back form whose `in_base_idx` is 0, or equals `in_tgt_idx`, gives `out_illegal`=1 and `out_wb_en`=0. The address is still computed.
- R9: A cycle with `in_valid`=0 gives `out_valid`=0, `out_wb_en`=0 and `out_illegal`=0. `out_ea` and `out_wb_idx` keep the values from the last valid operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_update | input | 1 | 1 = write-back form, 0 = plain indexed form |
| in_base_idx | input | 5 | Base register number |
| in_tgt_idx | input | 5 | Target (load destination) register number |
| in_base_val | input | 64 | Contents of the base register |
| in_index_val | input | 64 | Contents of the index register |
| in_shamt | input | 2 | Shift field; the index is scaled by 2^(field+1) |
| out_valid | output | 1 | Result valid |
| out_ea | output | 64 | Effective address |
| out_wb_en | output | 1 | Request to write `out_ea` into the base register |
| out_wb_idx | output | 5 | Register number for the write-back |
| out_illegal | output | 1 | Write-back form with an illegal register pairing |

## Verification
The stage holds only one register, so any wrong state shows at the outputs one cycle after the operation that caused it. Errors of this kind appear on `out_ea` for a wrong base choice or shift amount, and on `out_wb_en` or `out_illegal` for wrong form decoding. The state does not carry over between operations beyond the address held during idle cycles. For that reason, each vector is checked in the cycle right after it is driven. The idle-cycle check catches an address that fails to hold, or a stale write-back request.

// File: rtl/sia_pkg.sv
package sia_pkg;

    localparam int XLEN  = 64;
    localparam int REG_W = 5;
    localparam int SH_W  = 2;

    typedef enum logic {
        FORM_INDEXED = 1'b0,
        FORM_UPDATE  = 1'b1
    } sia_form_e;

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  ea;
        logic             wb_en;
        logic [REG_W-1:0] wb_idx;
        logic             illegal;
    } sia_result_t;

    function automatic logic reg_is_zero(input logic [REG_W-1:0] r);
        return (r == '0);
    endfunction

endpackage

// File: rtl/sia_base_sel.sv
module sia_base_sel
    import sia_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int RW = REG_W
) (
    input  sia_form_e        form,
    input  logic [RW-1:0]    base_idx,
    input  logic [DW-1:0]    base_val,
    output logic [DW-1:0]    base_op
);
    // Register 0 reads as literal zero only in the plain indexed form.
    always_comb begin
        if (form == FORM_INDEXED && base_idx == '0)
            base_op = '0;
        else
            base_op = base_val;
    end
endmodule

// File: rtl/sia_index_scale.sv
module sia_index_scale
    import sia_pkg::*;
#(
    parameter int DW  = XLEN,
    parameter int SHW = SH_W
) (
    input  logic [DW-1:0]  index_val,
    input  logic [SHW-1:0] shamt,
    output logic [DW-1:0]  scaled
);
    localparam int NSCALE = 1 << SHW;

    logic [DW-1:0] cand [NSCALE];

    // One fixed-shift candidate per field value; the field only selects.
    for (genvar g = 0; g < NSCALE; g++) begin : g_scale
        assign cand[g] = index_val << (g + 1);
    end

    assign scaled = cand[shamt];
endmodule

// File: rtl/sia_wb_ctrl.sv
module sia_wb_ctrl
    import sia_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  sia_form_e      form,
    input  logic [RW-1:0]  base_idx,
    input  logic [RW-1:0]  tgt_idx,
    output logic           wb_en,
    output logic           illegal
);
    logic bad_pair;

    always_comb begin
        bad_pair = (base_idx == '0) || (base_idx == tgt_idx);
        illegal  = (form == FORM_UPDATE) && bad_pair;
        wb_en    = (form == FORM_UPDATE) && !bad_pair;
    end

    // R8: an illegal pairing never coexists with a write-back request
    always_comb begin
        assert_wb_not_illegal_R8: assert (!(wb_en && illegal));
    end
endmodule

// File: rtl/sia_agen.sv
module sia_agen
    import sia_pkg::*;
#(
    parameter int DW  = XLEN,
    parameter int RW  = REG_W,
    parameter int SHW = SH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_update,
    input  logic [RW-1:0]   in_base_idx,
    input  logic [RW-1:0]   in_tgt_idx,
    input  logic [DW-1:0]   in_base_val,
    input  logic [DW-1:0]   in_index_val,
    input  logic [SHW-1:0]  in_shamt,
    output logic            out_valid,
    output logic [DW-1:0]   out_ea,
    output logic            out_wb_en,
    output logic [RW-1:0]   out_wb_idx,
    output logic            out_illegal
);
    sia_form_e     form;
    logic [DW-1:0] base_op;
    logic [DW-1:0] scaled;
    logic [DW-1:0] ea_next;
    logic          wb_en_n;
    logic          illegal_n;

    logic          r_valid;
    logic [DW-1:0] r_ea;
    logic          r_wb_en;
    logic [RW-1:0] r_wb_idx;
    logic          r_illegal;

    assign form = sia_form_e'(in_update);

    sia_base_sel #(.DW(DW), .RW(RW)) u_base (
        .form     (form),
        .base_idx (in_base_idx),
        .base_val (in_base_val),
        .base_op  (base_op)
    );

    sia_index_scale #(.DW(DW), .SHW(SHW)) u_scale (
        .index_val (in_index_val),
        .shamt     (in_shamt),
        .scaled    (scaled)
    );

    sia_wb_ctrl #(.RW(RW)) u_wb (
        .form     (form),
        .base_idx (in_base_idx),
        .tgt_idx  (in_tgt_idx),
        .wb_en    (wb_en_n),
        .illegal  (illegal_n)
    );

    // Modulo-2^DW add; the carry out of the top bit is dropped.
    assign ea_next = base_op + scaled;

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid   <= 1'b0;
            r_ea      <= '0;
            r_wb_en   <= 1'b0;
            r_wb_idx  <= '0;
            r_illegal <= 1'b0;
        end else begin
            r_valid   <= in_valid;
            r_wb_en   <= in_valid && wb_en_n;
            r_illegal <= in_valid && illegal_n;
            if (in_valid) begin
                r_ea     <= ea_next;
                r_wb_idx <= in_base_idx;
            end
        end
    end

    assign out_valid   = r_valid;
    assign out_ea      = r_ea;
    assign out_wb_en   = r_wb_en;
    assign out_wb_idx  = r_wb_idx;
    assign out_illegal = r_illegal;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_wb_en && !out_illegal));
    assert_ea_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_ea));
    assert_indexed_no_wb_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_update) |=> (!out_wb_en && !out_illegal));
    assert_zero_base_update_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_update && in_base_idx == '0) |=> (out_illegal && !out_wb_en));
    assert_wb_reg_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        out_wb_en |-> (out_wb_idx != '0 && out_valid));
    assert_indexed_zero_base_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_update && in_base_idx == '0) |=> out_ea == $past(scaled));
endmodule

// File: tb/sia_agen_tb.sv
module sia_agen_tb;

    typedef struct packed {
        logic        upd;
        logic [4:0]  bidx;
        logic [4:0]  tidx;
        logic [63:0] bval;
        logic [63:0] idx;
        logic [1:0]  sh;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0,  5'd3, 64'hDEAD,                 64'h10,                  2'd0},
        '{1'b0, 5'd7,  5'd3, 64'h1000,                 64'h10,                  2'd3},
        '{1'b1, 5'd7,  5'd3, 64'h1000,                 64'h1,                   2'd1},
        '{1'b1, 5'd0,  5'd3, 64'h500,                  64'h2,                   2'd2},
        '{1'b1, 5'd4,  5'd4, 64'h8,                    64'h1,                   2'd0},
        '{1'b0, 5'd9,  5'd1, 64'hFFFF_FFFF_FFFF_FFF0,  64'h8,                   2'd0},
        '{1'b0, 5'd2,  5'd1, 64'h0,                    64'h8000_0000_0000_0001, 2'd0},
        '{1'b1, 5'd31, 5'd0, 64'h100,                  64'hFFFF_FFFF_FFFF_FFFF, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_update;
    logic [4:0]  in_base_idx;
    logic [4:0]  in_tgt_idx;
    logic [63:0] in_base_val;
    logic [63:0] in_index_val;
    logic [1:0]  in_shamt;
    logic        out_valid;
    logic [63:0] out_ea;
    logic        out_wb_en;
    logic [4:0]  out_wb_idx;
    logic        out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    sia_agen u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_update    (in_update),
        .in_base_idx  (in_base_idx),
        .in_tgt_idx   (in_tgt_idx),
        .in_base_val  (in_base_val),
        .in_index_val (in_index_val),
        .in_shamt     (in_shamt),
        .out_valid    (out_valid),
        .out_ea       (out_ea),
        .out_wb_en    (out_wb_en),
        .out_wb_idx   (out_wb_idx),
        .out_illegal  (out_illegal)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_ea(input vec_t v);
        logic [63:0] b;
        b = (v.upd || v.bidx != 5'd0) ? v.bval : 64'd0;
        return b + (v.idx << (int'(v.sh) + 1));
    endfunction

    task automatic drive(input vec_t v);
        in_valid     = 1'b1;
        in_update    = v.upd;
        in_base_idx  = v.bidx;
        in_tgt_idx   = v.tidx;
        in_base_val  = v.bval;
        in_index_val = v.idx;
        in_shamt     = v.sh;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b1;
        drive(VECS[1]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid",   64'(out_valid),   64'd0);
        check("R1 ea",      out_ea,           64'd0);
        check("R1 wb_en",   64'(out_wb_en),   64'd0);
        check("R1 wb_idx",  64'(out_wb_idx),  64'd0);
        check("R1 illegal", 64'(out_illegal), 64'd0);
        rst = 1'b0;

        // Back-to-back table walk: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic bad;
            logic [63:0] e_ea;
            drive(VECS[i]);
            @(negedge clk);
            bad  = VECS[i].upd && (VECS[i].bidx == 5'd0 || VECS[i].bidx == VECS[i].tidx);
            e_ea = exp_ea(VECS[i]);
            check("R2 valid", 64'(out_valid), 64'd1);
            check(VECS[i].upd ? "R5 ea" : (VECS[i].bidx == 0 ? "R4 ea" : "R3 ea"), out_ea, e_ea);
            check(VECS[i].upd ? "R6 wb_en" : "R7 wb_en", 64'(out_wb_en), 64'(VECS[i].upd && !bad));
            check(VECS[i].upd ? "R8 illegal" : "R7 illegal", 64'(out_illegal), 64'(bad));
            if (VECS[i].upd && !bad)
                check("R6 wb_idx", 64'(out_wb_idx), 64'(VECS[i].bidx));
        end

        // R9: idle cycle with different data must not disturb held state
        in_valid     = 1'b0;
        in_update    = 1'b1;
        in_base_idx  = 5'd12;
        in_tgt_idx   = 5'd1;
        in_base_val  = 64'h1234;
        in_index_val = 64'h5;
        @(negedge clk);
        check("R9 valid",   64'(out_valid),   64'd0);
        check("R9 wb_en",   64'(out_wb_en),   64'd0);
        check("R9 illegal", 64'(out_illegal), 64'd0);
        check("R9 ea",      out_ea,           exp_ea(VECS[NV-1]));
        check("R9 wb_idx",  64'(out_wb_idx),  64'(VECS[NV-1].bidx));

        // R8: write-back form with base equal to target, nonzero
        drive('{1'b1, 5'd6, 5'd6, 64'h40, 64'h3, 2'd1});
        @(negedge clk);
        check("R8 illegal same", 64'(out_illegal), 64'd1);
        check("R8 wb_en same",   64'(out_wb_en),   64'd0);
        check("R8 ea same",      out_ea,           64'h4C);

        // R1: reset in mid-stream clears outputs
        rst = 1'b1;
        @(negedge clk);
        check("R1 valid again", 64'(out_valid), 64'd0);
        check("R1 ea again",    out_ea,         64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule